// File: doc/BRIEF.md
# Control Endpoint Setup-Stage Tracker

This block handles the SETUP and status phases of control transfers on endpoint zero of a USB device controller. A packet engine sends it decoded events: a SETUP packet with its eight data bytes, an IN token addressed to endpoint zero, and the host's handshake after a packet sent by the device. The block chooses the handshake the device returns (ACK, NAK, or a zero-length data packet) and writes SETUP payloads and a stage-done marker into the write port of a receive FIFO. The FIFO itself sits outside the block.

Software takes part in the sequence through single-cycle control pulses. It enables the OUT side of the endpoint, reloads the back-to-back SETUP allowance, clears the control-IN NAK, and clears interrupts. The FIFO read side tells the block when a word is popped and gives that word's status code. This lets the block hold the setup-done interrupt back until the marker has actually been read. A host may resend a SETUP packet after it loses the ACK. Every such copy is accepted and stored, and software acts only on the most recent one.

Top module: `usb_ep0_setup_tracker`

## Requirements
- R1: While `out_ena` is 1, a `setup_valid` pulse gives `hs_ack` high in the next cycle. It also writes two FIFO words with status code 4'h6: `setup_data[31:0]` in the next cycle and `setup_data[63:32]` in the cycle after.
- R2: While `out_ena` is 0, a `setup_valid` pulse gives no handshake and no FIFO write. A `sw_out_ena` pulse only sets `out_ena`.
- R3: A `sw_cnt_reload` pulse sets `b2b_cnt` to 3. Each accepted SETUP, including a repeat of one already taken, lowers it by one.
- R4: When `b2b_cnt` is 0, a SETUP is still ACKed and stored, `b2b_cnt` stays 0, and `b2b_ovf` is set and held until a bus reset.
- R5: The first IN token after one or more SETUPs gets `hs_nak`. In the same cycle it writes one marker word, with status 4'h4 and data 0. Later IN tokens before the marker is popped get NAK and cause no write.
- R6: `irq_setup_done` rises in the cycle after the FIFO reports a pop of a word with status 4'h4. It does not rise when the marker is written.
- R7: In the status phase, an IN token gets NAK while the control-IN NAK is set. Each accepted SETUP sets that NAK again. After a `sw_clr_nak` pulse, an IN token gets `tx_zlp`. A later `host_ack` sets `irq_xfer_done` and clears `out_ena` in the same cycle.
- R8: `irq_rxflvl` is 1 exactly while the number of words written minus the number popped is nonzero.
- R9: `bus_reset` sets `b2b_cnt` to 0 and clears `b2b_ovf`, `out_ena` and both sticky interrupts in the next cycle. It also returns the tracker to idle, so the next IN token gets NAK.
- R10: An IN token with no preceding SETUP gets NAK and writes nothing.
- R11: `sw_irq_clr[0]` clears `irq_setup_done` and `sw_irq_clr[1]` clears `irq_xfer_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_reset | input | 1 | USB bus reset detected |
| setup_valid | input | 1 | Valid SETUP packet received |
| setup_data | input | 64 | Eight SETUP data bytes |
| in_tok | input | 1 | IN token for endpoint zero |
| host_ack | input | 1 | Host ACKed the device's last IN packet |
| rd_pop | input | 1 | Software popped one FIFO word |
| rd_sts | input | 4 | Status code of the popped word |
| sw_out_ena | input | 1 | Enable the OUT side for a new SETUP |
| sw_clr_nak | input | 1 | Clear the control-IN NAK |
| sw_cnt_reload | input | 1 | Reload the back-to-back counter to 3 |
| sw_irq_clr | input | 2 | Clear setup-done (bit 0) and transfer-complete (bit 1) |
| hs_ack | output | 1 | Send ACK |
| hs_nak | output | 1 | Send NAK |
| tx_zlp | output | 1 | Send a zero-length data packet |
| fifo_wr_en | output | 1 | FIFO write strobe |
| fifo_wr_sts | output | 4 | Status code of the written word |
| fifo_wr_data | output | 32 | Written word |
| b2b_cnt | output | CNT_W | Remaining back-to-back SETUP allowance |
| b2b_ovf | output | 1 | Sticky back-to-back overflow |
| out_ena | output | 1 | OUT side enabled |
| irq_rxflvl | output | 1 | Receive FIFO holds at least one word |
| irq_setup_done | output | 1 | Setup stage done, marker read |
| irq_xfer_done | output | 1 | Status IN acknowledged by host |

## Verification
A wrong phase state shows up on the very next IN token. The token either draws a ZLP where a NAK was due, or it writes a second marker, and either is visible one cycle after the token. A wrong occupancy count shows on `irq_rxflvl` after the last pop of a sequence, and a wrong counter shows on `b2b_cnt` one cycle after each SETUP. The bench walks a complete two-stage transfer that includes a repeated SETUP, runs the counter through overflow, and applies a bus reset partway through a stage. It compares each handshake and FIFO word in the cycle it is due.

// File: rtl/usb_ep0_setup_tracker.sv
module usb_ep0_setup_tracker #(
  parameter int CNT_W      = 2,
  parameter int CNT_RELOAD = 3,
  parameter int OCC_W      = 6,
  parameter logic [3:0] STS_SETUP = 4'h6,
  parameter logic [3:0] STS_DONE  = 4'h4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_reset,
  input  logic             setup_valid,
  input  logic [63:0]      setup_data,
  input  logic             in_tok,
  input  logic             host_ack,
  input  logic             rd_pop,
  input  logic [3:0]       rd_sts,
  input  logic             sw_out_ena,
  input  logic             sw_clr_nak,
  input  logic             sw_cnt_reload,
  input  logic [1:0]       sw_irq_clr,
  output logic             hs_ack,
  output logic             hs_nak,
  output logic             tx_zlp,
  output logic             fifo_wr_en,
  output logic [3:0]       fifo_wr_sts,
  output logic [31:0]      fifo_wr_data,
  output logic [CNT_W-1:0] b2b_cnt,
  output logic             b2b_ovf,
  output logic             out_ena,
  output logic             irq_rxflvl,
  output logic             irq_setup_done,
  output logic             irq_xfer_done
);

  localparam logic [CNT_W-1:0] RELOAD_V = CNT_W'(CNT_RELOAD);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_WAITPOP, S_STATUS, S_ZLP} phase_t;

  phase_t      state;
  logic        in_nak;
  logic        word1_pend;
  logic [31:0] hi_q;
  logic [OCC_W-1:0] occ;

  wire take_setup = setup_valid && out_ena;
  wire marker_pop = rd_pop && (rd_sts == STS_DONE);

  assign irq_rxflvl = (occ != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= S_IDLE;
      in_nak         <= 1'b1;
      word1_pend     <= 1'b0;
      hi_q           <= '0;
      hs_ack         <= 1'b0;
      hs_nak         <= 1'b0;
      tx_zlp         <= 1'b0;
      fifo_wr_en     <= 1'b0;
      fifo_wr_sts    <= '0;
      fifo_wr_data   <= '0;
      b2b_cnt        <= '0;
      b2b_ovf        <= 1'b0;
      out_ena        <= 1'b0;
      irq_setup_done <= 1'b0;
      irq_xfer_done  <= 1'b0;
    end else begin
      hs_ack     <= 1'b0;
      hs_nak     <= 1'b0;
      tx_zlp     <= 1'b0;
      fifo_wr_en <= 1'b0;
      if (bus_reset) begin
        state          <= S_IDLE;
        in_nak         <= 1'b1;
        word1_pend     <= 1'b0;
        b2b_cnt        <= '0;
        b2b_ovf        <= 1'b0;
        out_ena        <= 1'b0;
        irq_setup_done <= 1'b0;
        irq_xfer_done  <= 1'b0;
      end else begin
        if (sw_out_ena)    out_ena <= 1'b1;
        if (sw_clr_nak)    in_nak  <= 1'b0;
        if (sw_cnt_reload) b2b_cnt <= RELOAD_V;
        if (sw_irq_clr[0]) irq_setup_done <= 1'b0;
        if (sw_irq_clr[1]) irq_xfer_done  <= 1'b0;

        if (word1_pend) begin
          fifo_wr_en   <= 1'b1;
          fifo_wr_sts  <= STS_SETUP;
          fifo_wr_data <= hi_q;
          word1_pend   <= 1'b0;
        end

        if (take_setup) begin
          hs_ack       <= 1'b1;
          fifo_wr_en   <= 1'b1;
          fifo_wr_sts  <= STS_SETUP;
          fifo_wr_data <= setup_data[31:0];
          hi_q         <= setup_data[63:32];
          word1_pend   <= 1'b1;
          in_nak       <= 1'b1;
          state        <= S_SETUP;
          if (b2b_cnt != '0) b2b_cnt <= b2b_cnt - 1'b1;
          else               b2b_ovf <= 1'b1;
        end else if (in_tok) begin
          case (state)
            S_SETUP: begin
              hs_nak       <= 1'b1;
              fifo_wr_en   <= 1'b1;
              fifo_wr_sts  <= STS_DONE;
              fifo_wr_data <= '0;
              state        <= S_WAITPOP;
            end
            S_STATUS: begin
              if (in_nak) hs_nak <= 1'b1;
              else begin
                tx_zlp <= 1'b1;
                state  <= S_ZLP;
              end
            end
            S_ZLP:   tx_zlp <= 1'b1;
            default: hs_nak <= 1'b1;
          endcase
        end else if (host_ack && state == S_ZLP) begin
          irq_xfer_done <= 1'b1;
          out_ena       <= 1'b0;
          state         <= S_IDLE;
        end

        if (marker_pop && state == S_WAITPOP) begin
          irq_setup_done <= 1'b1;
          state          <= S_STATUS;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else        occ <= occ + OCC_W'(fifo_wr_en) - OCC_W'(rd_pop);
  end

  p_setup_acked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take_setup && !bus_reset |=> hs_ack && fifo_wr_en && fifo_wr_sts == STS_SETUP);

  p_second_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hs_ack && !bus_reset |=> fifo_wr_en && fifo_wr_sts == STS_SETUP);

  p_disabled_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    setup_valid && !out_ena && !bus_reset |=> !hs_ack);

  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    b2b_ovf && !bus_reset |=> b2b_ovf);

  p_marker_with_nak_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_en && fifo_wr_sts == STS_DONE |-> hs_nak);

  p_done_after_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_setup_done) |-> $past(rd_pop) && $past(rd_sts) == STS_DONE);

  p_nak_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_tok && in_nak && state == S_STATUS && !setup_valid && !bus_reset |=> hs_nak && !tx_zlp);

  p_ena_selfclear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_xfer_done) |-> !out_ena);

  p_rxflvl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_en && !rd_pop |=> irq_rxflvl);

  p_bus_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> b2b_cnt == '0 && !b2b_ovf && !out_ena && !irq_setup_done && !irq_xfer_done);

  p_event_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    word1_pend |-> !take_setup && !in_tok);

endmodule

// File: tb/usb_ep0_setup_tracker_bench.sv
module usb_ep0_setup_tracker_bench;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_reset = 0, setup_valid = 0, in_tok = 0, host_ack = 0, rd_pop = 0;
  logic [63:0] setup_data = '0;
  logic [3:0] rd_sts = '0;
  logic sw_out_ena = 0, sw_clr_nak = 0, sw_cnt_reload = 0;
  logic [1:0] sw_irq_clr = '0;
  logic hs_ack, hs_nak, tx_zlp, fifo_wr_en, b2b_ovf, out_ena;
  logic irq_rxflvl, irq_setup_done, irq_xfer_done;
  logic [3:0] fifo_wr_sts;
  logic [31:0] fifo_wr_data;
  logic [1:0] b2b_cnt;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_ep0_setup_tracker u_usb_ep0_setup_tracker (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .setup_valid(setup_valid),
    .setup_data(setup_data), .in_tok(in_tok), .host_ack(host_ack), .rd_pop(rd_pop),
    .rd_sts(rd_sts), .sw_out_ena(sw_out_ena), .sw_clr_nak(sw_clr_nak),
    .sw_cnt_reload(sw_cnt_reload), .sw_irq_clr(sw_irq_clr), .hs_ack(hs_ack),
    .hs_nak(hs_nak), .tx_zlp(tx_zlp), .fifo_wr_en(fifo_wr_en), .fifo_wr_sts(fifo_wr_sts),
    .fifo_wr_data(fifo_wr_data), .b2b_cnt(b2b_cnt), .b2b_ovf(b2b_ovf), .out_ena(out_ena),
    .irq_rxflvl(irq_rxflvl), .irq_setup_done(irq_setup_done), .irq_xfer_done(irq_xfer_done));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_sw(input int which);
    case (which)
      0: sw_out_ena = 1;
      1: sw_clr_nak = 1;
      2: sw_cnt_reload = 1;
      3: sw_irq_clr = 2'b11;
      default: bus_reset = 1;
    endcase
    @(negedge clk);
    sw_out_ena = 0; sw_clr_nak = 0; sw_cnt_reload = 0; sw_irq_clr = 0; bus_reset = 0;
  endtask

  task automatic send_setup(input logic [63:0] d, input bit take, input string req);
    setup_data = d; setup_valid = 1;
    @(negedge clk);
    setup_valid = 0;
    chk(hs_ack == take, req, hs_ack, take);
    chk(fifo_wr_en == take, req, fifo_wr_en, take);
    if (take) chk(fifo_wr_data == d[31:0] && fifo_wr_sts == 4'h6, req, fifo_wr_data, d[31:0]);
    @(negedge clk);
    chk(fifo_wr_en == take && !hs_ack, req, fifo_wr_en, take);
    if (take) chk(fifo_wr_data == d[63:32], req, fifo_wr_data, d[63:32]);
    @(negedge clk);
  endtask

  task automatic send_in(output logic ack, output logic nak, output logic zlp, output logic wr,
                         output logic [3:0] sts);
    in_tok = 1;
    @(negedge clk);
    in_tok = 0;
    ack = hs_ack; nak = hs_nak; zlp = tx_zlp; wr = fifo_wr_en; sts = fifo_wr_sts;
    @(negedge clk);
  endtask

  task automatic pop(input logic [3:0] s);
    rd_pop = 1; rd_sts = s;
    @(negedge clk);
    rd_pop = 0;
  endtask

  task automatic t_reset;
    chk(!hs_ack && !hs_nak && !tx_zlp && !fifo_wr_en, "reset", {hs_ack, hs_nak, tx_zlp}, 0);
    chk(b2b_cnt == 0 && !b2b_ovf && !out_ena, "reset", b2b_cnt, 0);
    chk(!irq_rxflvl && !irq_setup_done && !irq_xfer_done, "reset R8", irq_rxflvl, 0);
  endtask

  task automatic t_disabled;
    logic a, n, z, w; logic [3:0] s;
    send_setup(64'h1111_2222_3333_4444, 1'b0, "R2 disabled setup");
    chk(b2b_cnt == 0 && !irq_rxflvl, "R2 no side effect", b2b_cnt, 0);
    send_in(a, n, z, w, s);
    chk(n && !w && !z && !a, "R10 idle IN nak", {n, w}, 2'b10);
    pulse_sw(0);
    chk(out_ena && b2b_cnt == 0 && !irq_rxflvl, "R2 enable only", out_ena, 1);
  endtask

  task automatic t_two_stage;
    logic a, n, z, w; logic [3:0] s;
    pulse_sw(2);
    chk(b2b_cnt == 3, "R3 reload", b2b_cnt, 3);
    send_setup(64'hA1A2A3A4_B1B2B3B4, 1'b1, "R1 first setup");
    chk(b2b_cnt == 2, "R3 decrement", b2b_cnt, 2);
    chk(irq_rxflvl, "R8 level after setup", irq_rxflvl, 1);
    send_setup(64'hA1A2A3A4_B1B2B3B4, 1'b1, "R3 repeated setup");
    chk(b2b_cnt == 1, "R3 second decrement", b2b_cnt, 1);
    send_in(a, n, z, w, s);
    chk(n && w && s == 4'h4 && !z, "R5 marker with nak", {n, w, s}, 6'h34);
    chk(!irq_setup_done, "R6 not on write", irq_setup_done, 0);
    send_in(a, n, z, w, s);
    chk(n && !w, "R5 second IN no marker", {n, w}, 2'b10);
    for (int i = 0; i < 4; i++) pop(4'h6);
    chk(!irq_setup_done && irq_rxflvl, "R6 data pops only", irq_setup_done, 0);
    pop(4'h4);
    chk(irq_setup_done, "R6 after marker pop", irq_setup_done, 1);
    chk(!irq_rxflvl, "R8 empty", irq_rxflvl, 0);
    send_in(a, n, z, w, s);
    chk(n && !z, "R7 nak until cleared", {n, z}, 2'b10);
    pulse_sw(1);
    send_in(a, n, z, w, s);
    chk(z && !n, "R7 zlp after clear", {n, z}, 2'b01);
    host_ack = 1;
    @(negedge clk);
    host_ack = 0;
    chk(irq_xfer_done && !out_ena, "R7 xfer done and disable", {irq_xfer_done, out_ena}, 2'b10);
    sw_irq_clr = 2'b01;
    @(negedge clk);
    sw_irq_clr = 0;
    chk(!irq_setup_done && irq_xfer_done, "R11 clear bit0", {irq_setup_done, irq_xfer_done}, 2'b01);
    sw_irq_clr = 2'b10;
    @(negedge clk);
    sw_irq_clr = 0;
    chk(!irq_xfer_done, "R11 clear bit1", irq_xfer_done, 0);
  endtask

  task automatic t_overflow;
    pulse_sw(0);
    pulse_sw(2);
    for (int i = 0; i < 3; i++) send_setup(64'h0 + i, 1'b1, "R3 burst");
    chk(b2b_cnt == 0 && !b2b_ovf, "R3 reached zero", b2b_cnt, 0);
    send_setup(64'hDEAD_BEEF_0BAD_F00D, 1'b1, "R4 setup at zero");
    chk(b2b_cnt == 0 && b2b_ovf, "R4 overflow flag", {b2b_cnt, b2b_ovf}, 1);
    pulse_sw(2);
    chk(b2b_ovf, "R4 sticky", b2b_ovf, 1);
    for (int i = 0; i < 8; i++) pop(4'h6);
    chk(!irq_rxflvl, "R8 drained", irq_rxflvl, 0);
  endtask

  task automatic t_bus_reset;
    logic a, n, z, w; logic [3:0] s;
    pulse_sw(1);
    pulse_sw(4);
    chk(b2b_cnt == 0 && !b2b_ovf && !out_ena, "R9 cleared", {b2b_cnt, b2b_ovf, out_ena}, 0);
    chk(!irq_setup_done && !irq_xfer_done, "R9 irqs cleared", irq_setup_done, 0);
    send_in(a, n, z, w, s);
    chk(n && !z && !w, "R9 idle nak", {n, z, w}, 3'b100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_two_stage();
    t_overflow();
    t_bus_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=0 exp=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule